// File: doc/BRIEF.md
# Single-Bit Error Corrector Using the CRC Syndrome

This block holds one received frame, a run of data bytes followed by the check bytes. It decides whether the frame is clean, holds one flipped bit that it can repair, or cannot be repaired. Software or an upstream block writes the frame bytes through a simple byte port and pulses `start`. The block then feeds the whole frame, data and check field together, through a CRC division register one bit per clock. The remainder left over is the syndrome: the CRC computed over the data, XORed with the received CRC.

A zero syndrome ends the job at once. If the syndrome is nonzero and repair is enabled, a second register produces, one position per clock, the syndrome that a lone error at each bit position would leave. The search starts at the last bit of the check field and walks toward the first data bit. On a match the block inverts that bit in its buffer and reports its index. If no position matches, the frame is reported uncorrectable and the buffer is left as it was.

Repair is only sound while the frame is shorter than the period of the generator polynomial, because only then does every position give a distinct syndrome. Repair also makes random garbage look valid far more often. For that reason `fix_en` can turn the search off, so that the block only detects errors.

Top module: `crc_bitfix`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `busy`, `done`, `corrected` and `uncorrectable` are 0 and `err_pos` is 0.
- R2: A byte written with `wr_en` at `wr_addr` while idle can be read back on `rd_data` at the same `rd_addr` in the same cycle the address is applied. Bytes 0 to DATA_BYTES-1 hold the data and the last CRC_W/8 bytes hold the check field. Frame bit index b is bit 7-(b mod 8) of byte b/8, so index 0 is the first bit sent.
- R3: The CRC uses the generator x^8+x^4+x^3+x^2+1 (POLY 0x1D), starts from zero, has no final inversion and takes bits most significant first. A frame whose syndrome is zero gives `done` with `corrected`=0 and `uncorrectable`=0 exactly FRAME_BITS+1 cycles after the edge that samples `start`, with no search.
- R4: With `fix_en`=1, a frame with exactly one flipped bit at any index b, including bits of the check field, gives `corrected`=1 and `err_pos`=b, and the buffer then holds the original frame exactly.
- R5: The search tests one position per clock, starting from index FRAME_BITS-1 and moving down. A repair at index b therefore raises `done` exactly 2*FRAME_BITS+1-b cycles after the start edge.
- R6: A nonzero syndrome that matches no position gives `uncorrectable`=1 exactly 2*FRAME_BITS+1 cycles after the start edge, and the buffer is left unchanged.
- R7: `fix_en` is sampled with `start`. With it at 0, any nonzero syndrome gives `uncorrectable`=1 exactly FRAME_BITS+1 cycles after the start edge, and the buffer is left unchanged.
- R8: `done` is high for one cycle. `busy` is high from the cycle after the start edge until `done` rises and is low while `done` is high. The result outputs hold their values until the next accepted start.
- R9: While `busy` is high, writes to the buffer and further `start` pulses have no effect.
- R10: A frame with two flipped bits is never reported clean. With repair on, it is either reported uncorrectable or repaired at the single position whose syndrome equals its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte write strobe into the frame buffer |
| wr_addr | input | ADDR_W | Byte address for writes |
| wr_data | input | 8 | Byte to write |
| rd_addr | input | ADDR_W | Byte address for reads |
| rd_data | output | 8 | Buffer byte at `rd_addr` (0 when out of range) |
| start | input | 1 | Pulse that begins a check of the stored frame |
| fix_en | input | 1 | 1 allows single-bit repair, 0 detects only |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| corrected | output | 1 | A single bit was located and inverted |
| uncorrectable | output | 1 | Syndrome nonzero and no repair made |
| err_pos | output | IDX_W | Frame bit index that was inverted |

## Verification
A wrong syndrome register shows as a frame verdict that disagrees with the bench's own CRC, one verdict per frame, on the first job that carries an error. A generator register that steps from the wrong seed or with the wrong feedback reports a wrong `err_pos` or damages the buffer. The sweep of every single-bit position exposes this within the first few repairs. An off-by-one in the position counter or the state sequence moves the `done` pulse, and the exact latency checks on clean, repaired and unrepairable frames catch it on the first job. A write that slips through while busy shows up as a changed byte when the buffer is read back after that job.

// File: rtl/crc_fix_pkg.sv
package crc_fix_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_JUDGE,
        ST_HUNT
    } fix_state_e;

    function automatic int frame_bit_count(input int data_bytes, input int crc_w);
        return (data_bytes + crc_w / 8) * 8;
    endfunction

endpackage

// File: rtl/crc_frame_buf.sv
module crc_frame_buf #(
    parameter int FRAME_BYTES = 16,
    parameter int ADDR_W      = 5,
    parameter int IDX_W       = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              lock,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic              bit_val,
    input  logic              flip_en,
    input  logic [IDX_W-1:0]  flip_idx
);
    localparam int BYTE_AW = IDX_W - 3;

    logic [FRAME_BYTES-1:0][7:0] mem;
    logic wr_ok, rd_ok;

    assign wr_ok = wr_en && !lock && (wr_addr < ADDR_W'(FRAME_BYTES));
    assign rd_ok = rd_addr < ADDR_W'(FRAME_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else begin
            if (wr_ok)
                mem[wr_addr[BYTE_AW-1:0]] <= wr_data;
            if (flip_en)
                mem[flip_idx[IDX_W-1:3]][3'd7 - flip_idx[2:0]] <=
                    ~mem[flip_idx[IDX_W-1:3]][3'd7 - flip_idx[2:0]];
        end
    end

    assign rd_data = rd_ok ? mem[rd_addr[BYTE_AW-1:0]] : 8'h00;
    assign bit_val = mem[bit_idx[IDX_W-1:3]][3'd7 - bit_idx[2:0]];

    // R9
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lock && !flip_en) |=> $stable(mem));

endmodule

// File: rtl/crc_lfsr_unit.sv
module crc_lfsr_unit #(
    parameter int               CRC_W = 8,
    parameter logic [CRC_W-1:0] POLY  = 8'h1D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             bit_in,
    input  logic             gen_load,
    input  logic             gen_step,
    output logic [CRC_W-1:0] syn,
    output logic [CRC_W-1:0] gen
);
    // Division register: remainder of the whole received sequence.
    always_ff @(posedge clk) begin
        if (rst || clr)
            syn <= '0;
        else if (shift_en)
            syn <= {syn[CRC_W-2:0], bit_in} ^ (syn[CRC_W-1] ? POLY : '0);
    end

    // Candidate register: x^i mod P for a lone error i bits from the end.
    always_ff @(posedge clk) begin
        if (rst)
            gen <= '0;
        else if (gen_load)
            gen <= CRC_W'(1);
        else if (gen_step)
            gen <= {gen[CRC_W-2:0], 1'b0} ^ (gen[CRC_W-1] ? POLY : '0);
    end

    // R5
    cand_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        gen_step |=> (gen != '0));

endmodule

// File: rtl/crc_fix_ctrl.sv
module crc_fix_ctrl
    import crc_fix_pkg::*;
#(
    parameter int FRAME_BITS = 128,
    parameter int IDX_W      = 7,
    parameter int CRC_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             fix_en,
    input  logic [CRC_W-1:0] syn,
    input  logic [CRC_W-1:0] gen,
    output logic             busy,
    output logic             lfsr_clr,
    output logic             shift_en,
    output logic             gen_load,
    output logic             gen_step,
    output logic [IDX_W-1:0] bit_idx,
    output logic             flip_en,
    output logic [IDX_W-1:0] flip_idx,
    output logic             done,
    output logic             corrected,
    output logic             uncorrectable,
    output logic [IDX_W-1:0] err_pos
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    fix_state_e       state;
    logic [IDX_W-1:0] cnt;
    logic             fix_q;
    logic             hit;

    assign busy     = (state != ST_IDLE);
    assign lfsr_clr = (state == ST_IDLE) && start;
    assign shift_en = (state == ST_SCAN);
    assign bit_idx  = cnt;
    assign hit      = (state == ST_HUNT) && (gen == syn);
    assign gen_load = (state == ST_JUDGE);
    assign gen_step = (state == ST_HUNT) && !hit;
    assign flip_en  = hit;
    assign flip_idx = LAST_IDX - cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            cnt           <= '0;
            fix_q         <= 1'b0;
            done          <= 1'b0;
            corrected     <= 1'b0;
            uncorrectable <= 1'b0;
            err_pos       <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        fix_q         <= fix_en;
                        cnt           <= '0;
                        corrected     <= 1'b0;
                        uncorrectable <= 1'b0;
                        err_pos       <= '0;
                        state         <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (cnt == LAST_IDX) begin
                        cnt   <= '0;
                        state <= ST_JUDGE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_JUDGE: begin
                    if (syn == '0) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else if (!fix_q) begin
                        uncorrectable <= 1'b1;
                        done          <= 1'b1;
                        state         <= ST_IDLE;
                    end else begin
                        state <= ST_HUNT;
                    end
                end
                ST_HUNT: begin
                    if (hit) begin
                        corrected <= 1'b1;
                        err_pos   <= flip_idx;
                        done      <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (cnt == LAST_IDX) begin
                        uncorrectable <= 1'b1;
                        done          <= 1'b1;
                        state         <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(corrected && uncorrectable));

endmodule

// File: rtl/crc_bitfix.sv
module crc_bitfix
    import crc_fix_pkg::*;
#(
    parameter int               DATA_BYTES  = 15,
    parameter int               CRC_W       = 8,
    parameter logic [CRC_W-1:0] POLY        = 8'h1D,
    localparam int              FRAME_BYTES = DATA_BYTES + CRC_W / 8,
    localparam int              FRAME_BITS  = frame_bit_count(DATA_BYTES, CRC_W),
    localparam int              IDX_W       = $clog2(FRAME_BITS),
    localparam int              ADDR_W      = $clog2(FRAME_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              start,
    input  logic              fix_en,
    output logic              busy,
    output logic              done,
    output logic              corrected,
    output logic              uncorrectable,
    output logic [IDX_W-1:0]  err_pos
);
    logic             lfsr_clr, shift_en, gen_load, gen_step, flip_en, bit_val;
    logic [IDX_W-1:0] bit_idx, flip_idx;
    logic [CRC_W-1:0] syn, gen;

    crc_frame_buf #(
        .FRAME_BYTES(FRAME_BYTES),
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .lock    (busy),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .bit_idx (bit_idx),
        .bit_val (bit_val),
        .flip_en (flip_en),
        .flip_idx(flip_idx)
    );

    crc_lfsr_unit #(
        .CRC_W(CRC_W),
        .POLY (POLY)
    ) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .clr     (lfsr_clr),
        .shift_en(shift_en),
        .bit_in  (bit_val),
        .gen_load(gen_load),
        .gen_step(gen_step),
        .syn     (syn),
        .gen     (gen)
    );

    crc_fix_ctrl #(
        .FRAME_BITS(FRAME_BITS),
        .IDX_W     (IDX_W),
        .CRC_W     (CRC_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .fix_en       (fix_en),
        .syn          (syn),
        .gen          (gen),
        .busy         (busy),
        .lfsr_clr     (lfsr_clr),
        .shift_en     (shift_en),
        .gen_load     (gen_load),
        .gen_step     (gen_step),
        .bit_idx      (bit_idx),
        .flip_en      (flip_en),
        .flip_idx     (flip_idx),
        .done         (done),
        .corrected    (corrected),
        .uncorrectable(uncorrectable),
        .err_pos      (err_pos)
    );

    // R3
    clean_zero_syn_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !corrected && !uncorrectable) |-> (syn == '0));

    // R4
    fix_match_chk: assert property (@(posedge clk) disable iff (rst)
        (done && corrected) |-> (gen == syn));

endmodule

// File: tb/crc_bitfix_tb.sv
module crc_bitfix_tb;
    localparam int         DB   = 15;
    localparam int         FB   = 16;
    localparam int         N    = FB * 8;
    localparam int         AW   = 5;
    localparam int         IW   = 7;
    localparam logic [7:0] POLY = 8'h1D;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          start = 1'b0;
    logic          fix_en = 1'b1;
    logic          busy, done, corrected, uncorrectable;
    logic [IW-1:0] err_pos;

    int errors = 0;
    int checks = 0;

    logic [7:0] gold [FB];
    logic [7:0] sent [FB];
    logic [7:0] want [FB];
    logic [7:0] ss   [N];

    always #10 clk = ~clk;

    crc_bitfix u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .start(start), .fix_en(fix_en),
        .busy(busy), .done(done), .corrected(corrected),
        .uncorrectable(uncorrectable), .err_pos(err_pos)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // CRC over data bits (augmented form) XOR the received check byte.
    function automatic logic [7:0] syn_of(input logic [7:0] f [FB]);
        logic [7:0] r = 8'h00;
        for (int i = 0; i < DB; i++)
            for (int k = 7; k >= 0; k--) begin
                logic fb = r[7] ^ f[i][k];
                r = {r[6:0], 1'b0} ^ (fb ? POLY : 8'h00);
            end
        return r ^ f[FB-1];
    endfunction

    task automatic make_gold(input int seed);
        for (int i = 0; i < DB; i++) gold[i] = 8'((seed * 37 + i * 13 + (i * i) * seed) ^ (seed << 3));
        gold[FB-1] = 8'h00;
        gold[FB-1] = syn_of(gold);
    endtask

    task automatic write_frame(input logic [7:0] f [FB]);
        for (int i = 0; i < FB; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = AW'(i); wr_data = f[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_job(input bit fe, output int lat);
        @(negedge clk);
        fix_en = fe; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 3 * N) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic cmp_buf(input logic [7:0] f [FB], input string req);
        int bad = -1;
        for (int i = 0; i < FB; i++) begin
            rd_addr = AW'(i);
            #1;
            if (bad < 0 && rd_data !== f[i]) bad = i;
        end
        rd_addr = '0;
        chk(bad < 0, req, "buffer mismatch at byte", bad, -1);
    endtask

    // Expected single position whose lone syndrome equals s, or -1.
    function automatic int predict(input logic [7:0] s);
        for (int b = N - 1; b >= 0; b--)
            if (ss[b] == s) return b;
        return -1;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1", "busy/done in reset", {busy, done}, 0);
        chk(corrected == 0 && uncorrectable == 0 && err_pos == 0, "R1", "results in reset",
            {corrected, uncorrectable, 1'b0} | int'(err_pos), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
    endtask

    task automatic t_mem();
        make_gold(3);
        write_frame(gold);
        cmp_buf(gold, "R2");
        rd_addr = AW'(FB);
        #1;
        chk(rd_data == 8'h00, "R2", "out-of-range read", rd_data, 0);
        rd_addr = '0;
    endtask

    task automatic t_clean(input int seed);
        int lat;
        make_gold(seed);
        write_frame(gold);
        run_job(1'b1, lat);
        chk(lat == N + 1, "R3", "clean latency", lat, N + 1);
        chk(!corrected && !uncorrectable, "R3", "clean verdict", {corrected, uncorrectable}, 0);
        cmp_buf(gold, "R3");
    endtask

    task automatic t_single_all();
        int lat;
        make_gold(7);
        for (int b = 0; b < N; b++) begin
            sent = gold;
            sent[b / 8][7 - b % 8] = ~sent[b / 8][7 - b % 8];
            write_frame(sent);
            run_job(1'b1, lat);
            chk(corrected && !uncorrectable, "R4", "single-bit verdict", {corrected, uncorrectable}, 2);
            chk(int'(err_pos) == b, "R4", "err_pos", err_pos, b);
            chk(lat == 2 * N + 1 - b, "R5", "repair latency", lat, 2 * N + 1 - b);
            cmp_buf(gold, "R4");
        end
    endtask

    task automatic t_nofix();
        int lat;
        make_gold(11);
        sent = gold;
        sent[4][2] = ~sent[4][2];
        write_frame(sent);
        run_job(1'b0, lat);
        chk(lat == N + 1, "R7", "detect-only latency", lat, N + 1);
        chk(uncorrectable && !corrected, "R7", "detect-only verdict", {corrected, uncorrectable}, 1);
        cmp_buf(sent, "R7");
    endtask

    // Two-bit error, expected exactly from the syndrome table.
    task automatic t_pair(input int a, input int b, input string req);
        int lat, p;
        logic [7:0] s;
        sent = gold;
        sent[a / 8][7 - a % 8] = ~sent[a / 8][7 - a % 8];
        sent[b / 8][7 - b % 8] = ~sent[b / 8][7 - b % 8];
        s = syn_of(sent);
        p = predict(s);
        write_frame(sent);
        run_job(1'b1, lat);
        chk(corrected || uncorrectable, "R10", "two-bit reported clean", {corrected, uncorrectable}, 1);
        if (p < 0) begin
            chk(uncorrectable && !corrected, req, "no-match verdict", {corrected, uncorrectable}, 1);
            chk(lat == 2 * N + 1, req, "no-match latency", lat, 2 * N + 1);
            cmp_buf(sent, req);
        end else begin
            want = sent;
            want[p / 8][7 - p % 8] = ~want[p / 8][7 - p % 8];
            chk(corrected && int'(err_pos) == p, req, "miscorrect position", err_pos, p);
            cmp_buf(want, req);
        end
    endtask

    task automatic t_pairs();
        int fa = -1, fb = -1;
        make_gold(19);
        for (int b = 0; b < N; b++) begin
            for (int i = 0; i < FB; i++) want[i] = 8'h00;
            want[b / 8][7 - b % 8] = 1'b1;
            ss[b] = syn_of(want);
        end
        for (int a = 0; a < N && fa < 0; a++)
            for (int b = a + 1; b < N && fa < 0; b++) begin
                for (int i = 0; i < FB; i++) want[i] = 8'h00;
                want[a / 8][7 - a % 8] = 1'b1;
                want[b / 8][7 - b % 8] = 1'b1;
                if (predict(syn_of(want)) < 0) begin fa = a; fb = b; end
            end
        chk(fa >= 0, "R6", "found unmatched pair", fa, 0);
        if (fa >= 0) t_pair(fa, fb, "R6");
        t_pair(0, 1, "R10");
        t_pair(10, 100, "R10");
        t_pair(3, 64, "R10");
        t_pair(120, 127, "R10");
    endtask

    task automatic t_pulse();
        int lat;
        make_gold(23);
        sent = gold;
        sent[9][6] = ~sent[9][6];
        write_frame(sent);
        run_job(1'b1, lat);
        chk(done && !busy, "R8", "busy low with done", busy, 0);
        @(negedge clk);
        chk(!done, "R8", "done one cycle", done, 0);
        chk(corrected && int'(err_pos) == 9 * 8 + 1, "R8", "result held", err_pos, 73);
        @(negedge clk);
        fix_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R8", "busy after start", busy, 1);
        chk(!corrected && !uncorrectable, "R8", "results cleared at start",
            {corrected, uncorrectable}, 0);
        while (!done) @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        int lat;
        make_gold(29);
        write_frame(gold);
        @(negedge clk);
        fix_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        repeat (5) begin
            @(negedge clk); lat++;
        end
        wr_en = 1'b1; wr_addr = AW'(3); wr_data = ~gold[3]; start = 1'b1;
        @(negedge clk); lat++;
        wr_en = 1'b0; start = 1'b0;
        while (!done && lat < 3 * N) begin
            @(negedge clk); lat++;
        end
        chk(lat == N + 1, "R9", "latency with ignored start", lat, N + 1);
        chk(!corrected && !uncorrectable, "R9", "verdict with ignored write",
            {corrected, uncorrectable}, 0);
        cmp_buf(gold, "R9");
        repeat (4) begin
            @(negedge clk);
            chk(!done && !busy, "R9", "no second job", {done, busy}, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_mem();
        t_clean(1);
        t_clean(5);
        t_single_all();
        t_nofix();
        t_pairs();
        t_pulse();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule